// File: doc/BRIEF.md
# Adaptive Migration Threshold Controller

This block sets the access-count threshold that a row migration filter uses when it decides whether to copy a row from the slow, dense memory tier (PCM) into the fast DRAM cache tier. Time is cut into fixed quanta of `QUANT` cycles. During a quantum, three strobe inputs count the migrations issued and the reads and writes that DRAM served. In the last cycle of each quantum the block prices the migrations, which cost bus cycles, against the bank cycles saved by serving those requests from DRAM instead of PCM. It then moves the threshold by one hill-climbing step.

All device timing figures are inputs, so a controller can load them from configuration. The miss-count threshold used by the same filter is a fixed constant of 2, and this block presents it on a port. The new access threshold appears one cycle after the quantum ends. It stays unchanged until the next quantum ends.

Top module: `mig_thresh_tuner`

## Requirements
- R1: After reset, `acc_thresh` equals the parameter `A_INIT`, `last_net` is 0 and `eval_pulse` is 0.
- R2: `eval_pulse` is high for exactly one cycle at the end of every quantum. The first pulse comes `QUANT` cycles after reset is released, and later pulses come exactly `QUANT` cycles apart.
- R3: The quantum's net benefit appears on `last_net` in the cycle with `eval_pulse`, as a two's-complement value. It is computed as `reads*(t_rd_pcm - t_rd_dram) + writes*(t_wr_pcm - t_wr_dram) - migrations*t_migr`. A latency difference may be negative, and the arithmetic cannot overflow.
- R4: If the net benefit is negative, the threshold rises by one.
- R5: If the net benefit is zero or positive and strictly larger than the previous quantum's net benefit, the threshold rises by one. The previous net benefit is 0 after reset.
- R6: If the net benefit is zero or positive and strictly smaller than the previous one, the threshold falls by one. If it is equal to the previous one, the threshold is unchanged.
- R7: After each step the threshold is clamped to the range 1 to `a_max`, where an `a_max` of 0 counts as 1. This clamp also pulls the threshold down when `a_max` has been lowered below its current value.
- R8: `acc_thresh` changes only in the cycle that carries `eval_pulse` and is constant otherwise.
- R9: Event counts start from zero in every quantum. A quantum that has no strobes therefore evaluates to a net benefit of 0, whatever came before it.
- R10: `miss_thresh` is the constant 2 at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| migr_stb | input | 1 | One migration issued this cycle |
| dram_rd_stb | input | 1 | One read served by DRAM this cycle |
| dram_wr_stb | input | 1 | One write served by DRAM this cycle |
| a_max | input | A_W | Upper limit for the threshold (0 counts as 1) |
| t_migr | input | LAT_W | Bus cycles consumed by one migration |
| t_rd_dram | input | LAT_W | DRAM read latency in cycles |
| t_rd_pcm | input | LAT_W | PCM read latency in cycles |
| t_wr_dram | input | LAT_W | DRAM write latency in cycles |
| t_wr_pcm | input | LAT_W | PCM write latency in cycles |
| acc_thresh | output | A_W | Current access-count threshold |
| miss_thresh | output | A_W | Fixed miss-count threshold (2) |
| last_net | output | NET_W | Net benefit of the last completed quantum (signed) |
| eval_pulse | output | 1 | One-cycle marker: a quantum has just been evaluated |

## Verification
The hardest conditions to reach are the two ends of the clamp and a net benefit that exactly equals the previous one. Each of them needs a particular history across several quanta. The stimulus therefore chains whole quanta on purpose. It uses a run of migration-heavy quanta to push the threshold into its ceiling. It then uses a strictly shrinking series of read-only quanta to walk the threshold down to its floor and hold it there. Two identical quanta back to back produce the equal case. Separate quanta lower `a_max` below the current threshold, set it to 0, and use negative latency differences.

// File: rtl/mtt_pkg.sv
package mtt_pkg;

    // Direction chosen by the hill-climbing step at a quantum boundary
    typedef enum logic [1:0] {
        STEP_HOLD = 2'd0,
        STEP_UP   = 2'd1,
        STEP_DOWN = 2'd2
    } mtt_step_e;

    localparam int unsigned MTT_NUM_EV = 3;   // migrations, DRAM reads, DRAM writes
    localparam int unsigned EV_MIGR    = 0;
    localparam int unsigned EV_RD      = 1;
    localparam int unsigned EV_WR      = 2;

endpackage

// File: rtl/mtt_qtimer.sv
module mtt_qtimer #(
    parameter int unsigned QUANT = 1024,
    parameter int unsigned QC_W  = $clog2(QUANT)
) (
    input  logic clk,
    input  logic rst_n,
    output logic bound_o
);

    typedef struct packed {
        logic [QC_W-1:0] cnt;
    } tmr_t;

    tmr_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (st_q.cnt == QC_W'(QUANT - 1))
            st_d.cnt = '0;
        else
            st_d.cnt = st_q.cnt + QC_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bound_o = (st_q.cnt == QC_W'(QUANT - 1));

    // R2: the position counter wraps to zero right after a boundary
    p_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bound_o |=> (st_q.cnt == '0));

    // R2: the position never leaves the quantum
    p_in_quant_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(st_q.cnt) < QUANT));

endmodule

// File: rtl/mtt_evcount.sv
module mtt_evcount #(
    parameter int unsigned NUM_EV = 3,
    parameter int unsigned CNT_W  = 11
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         bound_i,
    input  logic [NUM_EV-1:0]            stb_i,
    output logic [NUM_EV-1:0][CNT_W-1:0] tot_o
);

    logic [NUM_EV-1:0][CNT_W-1:0] cnt_q, cnt_d;

    for (genvar g = 0; g < NUM_EV; g++) begin : g_ev
        always_comb begin
            // total includes the strobe arriving in this very cycle
            tot_o[g] = cnt_q[g] + CNT_W'(stb_i[g]);
            cnt_d[g] = bound_i ? '0 : tot_o[g];
        end

        always_ff @(posedge clk) begin
            if (!rst_n) cnt_q[g] <= '0;
            else        cnt_q[g] <= cnt_d[g];
        end

        // R9: every quantum starts counting from zero
        p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
            bound_i |=> (cnt_q[g] == '0));
    end

endmodule

// File: rtl/mtt_neteval.sv
module mtt_neteval #(
    parameter int unsigned NUM_EV = 3,
    parameter int unsigned CNT_W  = 11,
    parameter int unsigned LAT_W  = 12,
    parameter int unsigned NET_W  = CNT_W + LAT_W + 4
) (
    input  logic [NUM_EV-1:0][CNT_W-1:0] tot_i,
    input  logic [LAT_W-1:0]             t_migr_i,
    input  logic [LAT_W-1:0]             t_rd_dram_i,
    input  logic [LAT_W-1:0]             t_rd_pcm_i,
    input  logic [LAT_W-1:0]             t_wr_dram_i,
    input  logic [LAT_W-1:0]             t_wr_pcm_i,
    output logic signed [NET_W-1:0]      net_o
);

    import mtt_pkg::*;

    logic signed [NET_W-1:0] n_migr, n_rd, n_wr;
    logic signed [NET_W-1:0] lat_mig, gain_rd, gain_wr;
    logic signed [NET_W-1:0] cost, benefit;

    always_comb begin
        // widen every operand to the full signed width before any product
        n_migr  = NET_W'($signed({1'b0, tot_i[EV_MIGR]}));
        n_rd    = NET_W'($signed({1'b0, tot_i[EV_RD]}));
        n_wr    = NET_W'($signed({1'b0, tot_i[EV_WR]}));
        lat_mig = NET_W'($signed({1'b0, t_migr_i}));
        gain_rd = NET_W'($signed({1'b0, t_rd_pcm_i})) - NET_W'($signed({1'b0, t_rd_dram_i}));
        gain_wr = NET_W'($signed({1'b0, t_wr_pcm_i})) - NET_W'($signed({1'b0, t_wr_dram_i}));
        cost    = n_migr * lat_mig;
        benefit = (n_rd * gain_rd) + (n_wr * gain_wr);
        net_o   = benefit - cost;
    end

endmodule

// File: rtl/mtt_hillstep.sv
module mtt_hillstep #(
    parameter int unsigned A_W    = 8,
    parameter int unsigned NET_W  = 27,
    parameter int unsigned A_INIT = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    bound_i,
    input  logic signed [NET_W-1:0] net_i,
    input  logic [A_W-1:0]          a_max_i,
    output logic [A_W-1:0]          a_o,
    output logic signed [NET_W-1:0] prev_o,
    output logic                    pulse_o
);

    import mtt_pkg::*;

    typedef struct packed {
        logic [A_W-1:0]          a;
        logic signed [NET_W-1:0] prev;
        logic                    pulse;
    } hs_t;

    hs_t        st_q, st_d;
    mtt_step_e  step;
    logic [A_W-1:0] a_lim;
    logic [A_W:0]   cand;

    always_comb begin
        st_d       = st_q;
        st_d.pulse = bound_i;
        a_lim      = (a_max_i == '0) ? A_W'(1) : a_max_i;

        if (net_i < 0)
            step = STEP_UP;          // migrations cost more than they save
        else if (net_i > st_q.prev)
            step = STEP_UP;          // benefit still climbing
        else if (net_i < st_q.prev)
            step = STEP_DOWN;        // threshold too strict
        else
            step = STEP_HOLD;

        case (step)
            STEP_UP:   cand = {1'b0, st_q.a} + (A_W+1)'(1);
            STEP_DOWN: cand = {1'b0, st_q.a} - (A_W+1)'(1);
            default:   cand = {1'b0, st_q.a};
        endcase

        if (cand > {1'b0, a_lim}) cand = {1'b0, a_lim};
        if (cand == '0)           cand = (A_W+1)'(1);

        if (bound_i) begin
            st_d.a    = cand[A_W-1:0];
            st_d.prev = net_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.a     <= A_W'(A_INIT);
            st_q.prev  <= '0;
            st_q.pulse <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign a_o     = st_q.a;
    assign prev_o  = st_q.prev;
    assign pulse_o = st_q.pulse;

    // R8: no movement outside a boundary
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !bound_i |=> $stable(st_q.a));

    // R7: never below one
    p_floor_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.a != '0));

    // R7: within the limit right after an evaluation
    p_ceil_r7: assert property (@(posedge clk) disable iff (!rst_n)
        bound_i |=> (st_q.a <= $past(a_lim)));

    // R4: a loss raises the threshold when there is headroom
    p_up_loss_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bound_i && (net_i < 0) && (st_q.a < a_lim))
        |=> (st_q.a == $past(st_q.a) + A_W'(1)));

    // R6: a shrinking gain lowers the threshold when there is room
    p_down_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bound_i && (net_i >= 0) && (net_i < st_q.prev) && (st_q.a > A_W'(1)) && (st_q.a <= a_lim))
        |=> (st_q.a == $past(st_q.a) - A_W'(1)));

    // R5: the stored reference follows the last evaluation
    p_prev_r5: assert property (@(posedge clk) disable iff (!rst_n)
        bound_i |=> (st_q.prev == $past(net_i)));

endmodule

// File: rtl/mig_thresh_tuner.sv
module mig_thresh_tuner #(
    parameter int unsigned QUANT    = 1024,
    parameter int unsigned A_W      = 8,
    parameter int unsigned LAT_W    = 12,
    parameter int unsigned A_INIT   = 4,
    parameter int unsigned MISS_THR = 2,
    parameter int unsigned CNT_W    = $clog2(QUANT + 1),
    parameter int unsigned NET_W    = CNT_W + LAT_W + 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    migr_stb,
    input  logic                    dram_rd_stb,
    input  logic                    dram_wr_stb,
    input  logic [A_W-1:0]          a_max,
    input  logic [LAT_W-1:0]        t_migr,
    input  logic [LAT_W-1:0]        t_rd_dram,
    input  logic [LAT_W-1:0]        t_rd_pcm,
    input  logic [LAT_W-1:0]        t_wr_dram,
    input  logic [LAT_W-1:0]        t_wr_pcm,
    output logic [A_W-1:0]          acc_thresh,
    output logic [A_W-1:0]          miss_thresh,
    output logic signed [NET_W-1:0] last_net,
    output logic                    eval_pulse
);

    import mtt_pkg::*;

    localparam int unsigned QC_W = (QUANT > 1) ? $clog2(QUANT) : 1;

    logic                                 bound;
    logic [MTT_NUM_EV-1:0]                stb;
    logic [MTT_NUM_EV-1:0][CNT_W-1:0]     tot;
    logic signed [NET_W-1:0]              net;

    assign stb[EV_MIGR] = migr_stb;
    assign stb[EV_RD]   = dram_rd_stb;
    assign stb[EV_WR]   = dram_wr_stb;

    mtt_qtimer #(.QUANT(QUANT), .QC_W(QC_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .bound_o (bound)
    );

    mtt_evcount #(.NUM_EV(MTT_NUM_EV), .CNT_W(CNT_W)) u_count (
        .clk     (clk),
        .rst_n   (rst_n),
        .bound_i (bound),
        .stb_i   (stb),
        .tot_o   (tot)
    );

    mtt_neteval #(.NUM_EV(MTT_NUM_EV), .CNT_W(CNT_W), .LAT_W(LAT_W), .NET_W(NET_W)) u_eval (
        .tot_i       (tot),
        .t_migr_i    (t_migr),
        .t_rd_dram_i (t_rd_dram),
        .t_rd_pcm_i  (t_rd_pcm),
        .t_wr_dram_i (t_wr_dram),
        .t_wr_pcm_i  (t_wr_pcm),
        .net_o       (net)
    );

    mtt_hillstep #(.A_W(A_W), .NET_W(NET_W), .A_INIT(A_INIT)) u_step (
        .clk     (clk),
        .rst_n   (rst_n),
        .bound_i (bound),
        .net_i   (net),
        .a_max_i (a_max),
        .a_o     (acc_thresh),
        .prev_o  (last_net),
        .pulse_o (eval_pulse)
    );

    assign miss_thresh = A_W'(MISS_THR);

    // R10: the miss threshold never moves
    p_miss_const_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_thresh == A_W'(2)));

    // R2: an evaluation pulse lasts one cycle only
    p_one_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        eval_pulse |=> !eval_pulse);

endmodule

// File: tb/mig_thresh_tuner_bench.sv
module mig_thresh_tuner_bench;

    localparam int unsigned QUANT  = 16;
    localparam int unsigned A_W    = 6;
    localparam int unsigned LAT_W  = 12;
    localparam int unsigned A_INIT = 4;
    localparam int unsigned CNT_W  = $clog2(QUANT + 1);
    localparam int unsigned NET_W  = CNT_W + LAT_W + 4;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    migr_stb = 1'b0;
    logic                    dram_rd_stb = 1'b0;
    logic                    dram_wr_stb = 1'b0;
    logic [A_W-1:0]          a_max = 8;
    logic [LAT_W-1:0]        t_migr = 200;
    logic [LAT_W-1:0]        t_rd_dram = 10;
    logic [LAT_W-1:0]        t_rd_pcm = 40;
    logic [LAT_W-1:0]        t_wr_dram = 10;
    logic [LAT_W-1:0]        t_wr_pcm = 110;
    logic [A_W-1:0]          acc_thresh;
    logic [A_W-1:0]          miss_thresh;
    logic signed [NET_W-1:0] last_net;
    logic                    eval_pulse;

    always #5 clk = ~clk;

    mig_thresh_tuner #(.QUANT(QUANT), .A_W(A_W), .LAT_W(LAT_W), .A_INIT(A_INIT)) u_mig_thresh_tuner (
        .clk         (clk),
        .rst_n       (rst_n),
        .migr_stb    (migr_stb),
        .dram_rd_stb (dram_rd_stb),
        .dram_wr_stb (dram_wr_stb),
        .a_max       (a_max),
        .t_migr      (t_migr),
        .t_rd_dram   (t_rd_dram),
        .t_rd_pcm    (t_rd_pcm),
        .t_wr_dram   (t_wr_dram),
        .t_wr_pcm    (t_wr_pcm),
        .acc_thresh  (acc_thresh),
        .miss_thresh (miss_thresh),
        .last_net    (last_net),
        .eval_pulse  (eval_pulse)
    );

    typedef struct {
        int     a;
        longint net;
        string  tag;
    } exp_t;

    exp_t   sb[$];
    int     n_chk = 0;
    int     n_bad = 0;
    bit     done = 0;
    int     m_a = A_INIT;
    longint m_prev = 0;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // driver: model the quantum, push the expectation, then drive the strobes
    task automatic run_q(input int nm, input int nr, input int nw, input string tag);
        longint net;
        int     lim;
        int     nxt;
        exp_t   e;
        net = longint'(nr) * (longint'(t_rd_pcm) - longint'(t_rd_dram))
            + longint'(nw) * (longint'(t_wr_pcm) - longint'(t_wr_dram))
            - longint'(nm) * longint'(t_migr);
        lim = (a_max == 0) ? 1 : int'(a_max);
        if (net < 0)            nxt = m_a + 1;
        else if (net > m_prev)  nxt = m_a + 1;
        else if (net < m_prev)  nxt = m_a - 1;
        else                    nxt = m_a;
        if (nxt > lim) nxt = lim;
        if (nxt < 1)   nxt = 1;
        m_a = nxt;
        m_prev = net;
        e.a = nxt; e.net = net; e.tag = tag;
        sb.push_back(e);
        for (int k = 0; k < int'(QUANT); k++) begin
            migr_stb    = (k < nm);
            dram_rd_stb = (k < nr);
            dram_wr_stb = (k < nw);
            @(negedge clk);
        end
        migr_stb = 0; dram_rd_stb = 0; dram_wr_stb = 0;
    endtask

    // monitor: period, stability and scoreboard comparison
    initial begin
        int gap;
        int last_a;
        exp_t e;
        gap = 0;
        last_a = A_INIT;
        @(posedge rst_n);
        forever begin
            @(posedge clk);
            gap++;
            @(negedge clk);
            if (eval_pulse) begin
                check(gap == int'(QUANT), "R2 period", gap, QUANT);
                gap = 0;
                if (sb.size() == 0) begin
                    check(0, "R2 unexpected pulse", 1, 0);
                end else begin
                    e = sb.pop_front();
                    check(longint'(last_net) == e.net, {"R3 net ", e.tag}, longint'(last_net), e.net);
                    check(int'(acc_thresh) == e.a, {"A step ", e.tag}, acc_thresh, e.a);
                end
                last_a = acc_thresh;
            end else begin
                if (int'(acc_thresh) != last_a)
                    check(0, "R8 change off boundary", acc_thresh, last_a);
            end
            if (miss_thresh != 2)
                check(0, "R10 miss threshold", miss_thresh, 2);
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(acc_thresh == A_W'(A_INIT), "R1 threshold", acc_thresh, A_INIT);
        check(last_net == 0, "R1 net", last_net, 0);
        check(eval_pulse == 0, "R1 pulse", eval_pulse, 0);
        check(miss_thresh == 2, "R10 miss threshold", miss_thresh, 2);
        rst_n = 1;

        run_q(1, 4, 0, "R4 loss");                 // -80 -> up
        run_q(0, 2, 1, "R5 rising gain");          // 160 -> up
        run_q(0, 1, 0, "R6 shrinking gain");       // 30 -> down
        run_q(0, 1, 0, "R6 equal hold");           // 30 -> hold
        run_q(0, 0, 0, "R9 empty quantum");        // 0 -> down
        for (int i = 0; i < 6; i++)
            run_q(16, 0, 0, "R7 ceiling");
        for (int n = 16; n >= 0; n--)
            run_q(0, n, 0, "R7 floor walk");
        for (int i = 0; i < 3; i++)
            run_q(16, 0, 0, "R4 climb");
        a_max = 2;
        run_q(16, 0, 0, "R7 lowered limit");
        a_max = 0;
        run_q(16, 0, 0, "R7 zero limit");
        a_max = 8;
        t_rd_pcm = 10; t_wr_dram = 50; t_wr_pcm = 20;
        run_q(0, 7, 5, "R3 negative gain");
        t_migr = 4095; t_rd_dram = 0; t_rd_pcm = 4095; t_wr_dram = 0; t_wr_pcm = 4095;
        run_q(0, 16, 16, "R3 wide gain");
        run_q(16, 0, 0, "R3 wide cost");
        run_q(3, 0, 0, "R4 smaller loss");

        repeat (4) @(negedge clk);
        check(sb.size() == 0, "R2 all quanta evaluated", sb.size(), 0);
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
        $finish;
    end

endmodule